// File: doc/BRIEF.md
# Policy-Driven Clock Enable Controller

This block holds four clock enable masks, one for each power policy, and drives a vector of per-clock enable outputs from the mask of the policy now in force. Policy 0 draws the least power and policy 3 the most. After reset, policy 2 is in force and every clock is enabled. Software reaches the block through a single-cycle register port: a write strobe with an address and write data, and a combinational read-data output for the same address. The port accepts a write on every cycle and never applies back-pressure. All register fields are control or status fields, so no stream handshake is used.

Every register except the key register is protected. Software must first write the key value with its grant bit set before a protected write takes effect. To edit the masks, software first halts the policy engine through the stop register and then writes the masks. It then writes a target policy and starts the engine with a self-clearing start bit. A settle counter stands in for the voltage and frequency ramp. In direct-load mode the active policy takes the target at once and the start bit clears after the ramp. In auto-copy mode the target is copied into the active policy only when the ramp finishes. In both modes the clock enables change only when the operation completes.

Top module: `ccp_top`

## Requirements
- R1: After reset, the active and target policies are 2, all clock enables are 1, key access is off, the violation flag is 0, and the engine is neither busy nor halted.
- R2: A write to address 0 whose bits 31:8 equal 0xA5A500 sets key access to bit 0 of the write data. A write to address 0 with any other bits 31:8 changes nothing. Address 0 reads back with access in bit 0 and the violation flag in bit 1.
- R3: Without key access, a write to any address other than 0 is dropped and sets the violation flag. The flag stays set until reset.
- R4: Mask registers sit at addresses 4 to 7, for policies 0 to 3, and read back at the same addresses. A write to them takes effect only with key access and while the engine is halted. Otherwise it is dropped.
- R5: Writing 1 to bit 0 of address 3 while the engine is idle and not halted starts a stop sequence. Bit 0 of address 3 reads 1 for STOP_CYCLES cycles and then 0. After that, halted reads 1 in bit 3 of address 1. A stop request while the engine is already halted is ignored.
- R6: Writing 1 to bit 0 of address 1 while the engine is idle starts an operation. Busy, seen on the port and in bit 0 of address 1, reads 1 for SETTLE_CYCLES cycles and then clears by itself.
- R7: The target policy is written at address 2, bits 1:0. Address 2 reads the active policy in bits 3:2 and the target in bits 1:0. When the start write has bit 1 set (direct-load mode), the active policy takes the target in the cycle after the start write.
- R8: When the start write has bit 1 clear (auto-copy mode), the active policy keeps its value until the operation completes and then takes the target captured at start.
- R9: The clock enables take the mask of the captured target policy when an operation completes, and hold their value at every other time.
- R10: A start or stop write while an operation is busy is ignored. It does not extend the busy time and does not start a stop sequence.
- R11: Starting an operation clears the halted state, so mask writes are dropped again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Word address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| clk_en | output | NCLK | Per-clock enables of the policy in force |
| busy | output | 1 | An engine operation is in progress |
| active_policy | output | 2 | Policy now in force |

## Verification
Two pairs of events are made to land in the same window. In the first, a start or stop write arrives while the settle counter is still running. The bench drives the write two edges into the ramp, and the write is judged ignored if busy still falls exactly SETTLE_CYCLES cycles after the first start and the stop status stays 0. In the second, mask edits and key revocation fall close to engine transitions. Mask readback then shows whether a write landed while the engine was running or after access was withdrawn.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int NPOL     = 4;
  localparam int DW       = 32;
  localparam int AW       = 3;
  localparam logic [23:0] KEY_VAL = 24'hA5A500;

  localparam logic [AW-1:0] A_KEY  = 3'd0;
  localparam logic [AW-1:0] A_CTRL = 3'd1;
  localparam logic [AW-1:0] A_TGT  = 3'd2;
  localparam logic [AW-1:0] A_STOP = 3'd3;

  localparam int CTRL_START = 0;
  localparam int CTRL_DIRECT = 1;
  localparam int CTRL_HALTED = 3;

  typedef logic [1:0] policy_t;
endpackage

// File: rtl/ccp_keygate.sv
module ccp_keygate
  import ccp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [23:0]   key_field,
  input  logic          grant_bit,
  output logic          access,
  output logic          viol,
  output logic          wr_ok
);
  logic key_hit;

  assign key_hit = wr_en && (addr == A_KEY);
  assign wr_ok   = wr_en && (addr != A_KEY) && access;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      access <= 1'b0;
      viol   <= 1'b0;
    end else begin
      if (key_hit && (key_field == KEY_VAL))
        access <= grant_bit;
      if (wr_en && (addr != A_KEY) && !access)
        viol <= 1'b1;
    end
  end
endmodule

// File: rtl/ccp_maskbank.sv
module ccp_maskbank
  import ccp_pkg::*;
#(
  parameter int NCLK = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_ok,
  input  logic                      halted,
  input  logic [AW-1:0]             addr,
  input  logic [NCLK-1:0]           wr_mask,
  input  policy_t                   sel,
  output logic [NPOL-1:0][NCLK-1:0] masks,
  output logic [NCLK-1:0]           sel_mask
);
  for (genvar p = 0; p < NPOL; p++) begin : g_pol
    localparam logic [AW-1:0] MY_ADDR = AW'(NPOL + p);
    always_ff @(posedge clk) begin
      if (!rst_n)
        masks[p] <= '1;
      else if (wr_ok && halted && (addr == MY_ADDR))
        masks[p] <= wr_mask;
    end
  end

  assign sel_mask = masks[sel];
endmodule

// File: rtl/ccp_engine.sv
module ccp_engine
  import ccp_pkg::*;
#(
  parameter int      SETTLE_CYCLES = 4,
  parameter int      STOP_CYCLES   = 2,
  parameter policy_t RESET_POLICY  = 2'd2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_req,
  input  logic    direct,
  input  logic    stop_req,
  input  policy_t target,
  output logic    busy,
  output logic    stopping,
  output logic    halted,
  output logic    done,
  output policy_t active,
  output policy_t pend
);
  localparam int MAXC = (SETTLE_CYCLES > STOP_CYCLES) ? SETTLE_CYCLES : STOP_CYCLES;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYCLES - 1);
  localparam logic [CW-1:0] STOP_LD   = CW'(STOP_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      stopping <= 1'b0;
      halted   <= 1'b0;
      cnt      <= '0;
      active   <= RESET_POLICY;
      pend     <= RESET_POLICY;
    end else if (busy) begin
      if (cnt == '0) begin
        busy   <= 1'b0;
        active <= pend;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (stopping) begin
      if (cnt == '0) begin
        stopping <= 1'b0;
        halted   <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (start_req) begin
      busy   <= 1'b1;
      halted <= 1'b0;
      cnt    <= SETTLE_LD;
      pend   <= target;
      if (direct)
        active <= target;
    end else if (stop_req && !halted) begin
      stopping <= 1'b1;
      cnt      <= STOP_LD;
    end
  end
endmodule

// File: rtl/ccp_top.sv
module ccp_top
  import ccp_pkg::*;
#(
  parameter int      NCLK          = 32,
  parameter int      SETTLE_CYCLES = 4,
  parameter int      STOP_CYCLES   = 2,
  parameter policy_t RESET_POLICY  = 2'd2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  output logic [NCLK-1:0] clk_en,
  output logic            busy,
  output logic [1:0]      active_policy
);
  logic access_q, viol_q, wr_ok;
  logic busy_w, stopping_w, halted_w, done_w;
  policy_t active_w, pend_w, target_q;
  logic [NPOL-1:0][NCLK-1:0] masks_w;
  logic [NCLK-1:0] sel_mask_w;
  logic start_req, stop_req;

  ccp_keygate u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .key_field(wr_data[31:8]), .grant_bit(wr_data[0]),
    .access(access_q), .viol(viol_q), .wr_ok(wr_ok)
  );

  assign start_req = wr_ok && (addr == A_CTRL) && wr_data[CTRL_START];
  assign stop_req  = wr_ok && (addr == A_STOP) && wr_data[0];

  ccp_engine #(
    .SETTLE_CYCLES(SETTLE_CYCLES), .STOP_CYCLES(STOP_CYCLES),
    .RESET_POLICY(RESET_POLICY)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .direct(wr_data[CTRL_DIRECT]), .stop_req(stop_req), .target(target_q),
    .busy(busy_w), .stopping(stopping_w), .halted(halted_w), .done(done_w),
    .active(active_w), .pend(pend_w)
  );

  ccp_maskbank #(.NCLK(NCLK)) u_masks (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .halted(halted_w), .addr(addr),
    .wr_mask(wr_data[NCLK-1:0]), .sel(pend_w), .masks(masks_w),
    .sel_mask(sel_mask_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target_q <= RESET_POLICY;
      clk_en   <= '1;
    end else begin
      if (wr_ok && (addr == A_TGT))
        target_q <= wr_data[1:0];
      if (done_w)
        clk_en <= sel_mask_w;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr[2]) begin
      rd_data = DW'(masks_w[addr[1:0]]);
    end else begin
      case (addr)
        A_KEY:  rd_data = {30'd0, viol_q, access_q};
        A_CTRL: rd_data = {28'd0, halted_w, 2'b00, busy_w};
        A_TGT:  rd_data = {28'd0, active_w, target_q};
        A_STOP: rd_data = {31'd0, stopping_w};
        default: rd_data = '0;
      endcase
    end
  end

  assign busy          = busy_w;
  assign active_policy = active_w;
endmodule

// File: rtl/ccp_checker.sv
module ccp_checker #(
  parameter int NCLK = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [2:0]      addr,
  input logic [31:0]     wr_data,
  input logic            access,
  input logic            viol,
  input logic            busy,
  input logic            stopping,
  input logic [NCLK-1:0] clk_en
);
  AST_KEY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && wr_data == 32'hA5A50001) |=> access); // R2

  AST_KEY_REVOKE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && wr_data == 32'hA5A50000) |=> !access); // R2

  AST_VIOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != 3'd0 && !access) |=> viol); // R3

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol); // R3

  AST_EN_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_en) |-> $fell(busy)); // R9

  AST_NO_STOP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && stopping)); // R10
endmodule

bind ccp_top ccp_checker #(.NCLK(NCLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .access(access_q), .viol(viol_q), .busy(busy_w), .stopping(stopping_w),
  .clk_en(clk_en)
);

// File: tb/tb_ccp_top.sv
`timescale 1ns/1ps
module tb_ccp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] clk_en;
  logic        busy;
  logic [1:0]  active_policy;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ccp_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .clk_en(clk_en), .busy(busy), .active_policy(active_policy)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  waddr;
    logic [31:0] wdata;
    logic [3:0]  waits;
    logic [2:0]  caddr;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd5, 32'h0000000F, 4'd0, 3'd5, 32'hFFFFFFFF}, // R3 dropped
    '{1'b0, 3'd0, 32'h0,        4'd0, 3'd0, 32'h00000002}, // R3 flag
    '{1'b1, 3'd0, 32'h12345601, 4'd0, 3'd0, 32'h00000002}, // R2 bad key
    '{1'b1, 3'd0, 32'hA5A50001, 4'd0, 3'd0, 32'h00000003}, // R2 grant
    '{1'b1, 3'd5, 32'h0000000F, 4'd0, 3'd5, 32'hFFFFFFFF}, // R4 not halted
    '{1'b1, 3'd3, 32'h00000001, 4'd0, 3'd3, 32'h00000001}, // R5 stopping
    '{1'b0, 3'd0, 32'h0,        4'd2, 3'd3, 32'h00000000}, // R5 stopped
    '{1'b0, 3'd0, 32'h0,        4'd0, 3'd1, 32'h00000008}, // R5 halted
    '{1'b1, 3'd4, 32'h000000A5, 4'd0, 3'd4, 32'h000000A5}, // R4 mask0
    '{1'b1, 3'd5, 32'h00005A00, 4'd0, 3'd5, 32'h00005A00}, // R4 mask1
    '{1'b1, 3'd7, 32'h00FF00FF, 4'd0, 3'd7, 32'h00FF00FF}, // R4 mask3
    '{1'b1, 3'd2, 32'h00000001, 4'd0, 3'd2, 32'h00000009}  // R7 target
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rd_data;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 clk_en", clk_en, 32'hFFFFFFFF);
    check("R1 policy", {30'd0, active_policy}, 32'd2);
    rd(3'd0, v); check("R1 key", v, 32'd0);
    rd(3'd1, v); check("R1 ctrl", v, 32'd0);
    rd(3'd2, v); check("R1 tgt", v, 32'd10);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].waddr, VEC[i].wdata);
      repeat (VEC[i].waits) @(negedge clk);
      rd(VEC[i].caddr, v);
      check($sformatf("vector %0d", i), v, VEC[i].exp);
    end

    // Auto-copy start (R8, R6, R11), stop during busy (R10)
    wr(3'd1, 32'h1);                      // start lands at E0
    rd(3'd1, v); check("R6 R11 busy, unhalted", v, 32'h1);
    rd(3'd2, v); check("R8 active held", v, 32'h9);
    check("R9 en held", clk_en, 32'hFFFFFFFF);
    wr(3'd3, 32'h1);                      // lands at E2
    rd(3'd3, v); check("R10 stop ignored", v, 32'h0);
    check("R6 busy mid", {31'd0, busy}, 32'h1);
    @(negedge clk);                       // after E3
    check("R6 busy last", {31'd0, busy}, 32'h1);
    @(negedge clk);                       // after E4
    check("R6 busy clear", {31'd0, busy}, 32'h0);
    rd(3'd2, v); check("R8 active copied", v, 32'h5);
    check("R9 en policy1", clk_en, 32'h00005A00);
    @(negedge clk);
    rd(3'd3, v); check("R10 no stop later", v, 32'h0);
    rd(3'd1, v); check("R10 R11 not halted", v, 32'h0);
    wr(3'd4, 32'h0);
    rd(3'd4, v); check("R4 R11 mask locked", v, 32'h000000A5);

    // Direct-load start (R7), start during busy (R10)
    wr(3'd2, 32'h3);
    rd(3'd2, v); check("R7 target3", v, 32'h7);
    wr(3'd1, 32'h3);                      // E0
    rd(3'd2, v); check("R7 active direct", v, 32'hF);
    check("R9 en held direct", clk_en, 32'h00005A00);
    wr(3'd1, 32'h1);                      // E2, ignored
    check("R10 busy", {31'd0, busy}, 32'h1);
    @(negedge clk);
    @(negedge clk);                       // after E4
    check("R10 no extension", {31'd0, busy}, 32'h0);
    check("R9 en policy3", clk_en, 32'h00FF00FF);
    check("R7 port policy", {30'd0, active_policy}, 32'd3);

    // Revocation (R2) then dropped write (R3)
    wr(3'd0, 32'hA5A50000);
    rd(3'd0, v); check("R2 revoke", v, 32'h2);
    wr(3'd2, 32'h0);
    rd(3'd2, v); check("R3 target kept", v, 32'hF);
    rd(3'd0, v); check("R3 sticky", v, 32'h2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule